// File: doc/BRIEF.md
# Dual-Line Serial DMA Request Decoder

This block sits on the host side of a low-pin-count peripheral bus. Two active-low request lines each come from a single peripheral and are never shared. A peripheral raises a request for a DMA channel by sending a short serial frame on its line, synchronous to the bus clock. The block decodes each frame and keeps one pending flag per channel. A frame can set the flag or cancel a request that is still waiting. Service logic elsewhere reads the pending flags, runs the transfer and then returns a service acknowledge with the channel number. The acknowledge clears that flag.

A frame is one low start bit, then three channel bits with the most significant first, then one ACT bit. A gap clock follows, and the line must be high during it. The line level is the bit value. Each line has its own receiver state machine. Its states are RX_IDLE, RX_CHAN, RX_ACT, RX_GAP and RX_ERR. The transitions are:

- RX_IDLE to RX_CHAN when a start bit is seen.
- RX_CHAN to RX_ACT after the last channel bit.
- RX_ACT to RX_GAP unconditionally.
- RX_GAP to RX_IDLE when the gap is high, which commits the frame.
- RX_GAP to RX_ERR when the gap is low, which drops the frame.
- RX_ERR to RX_IDLE once the line is seen high.

A shared pending table merges the committed frames from both lines and the acknowledges. A classifier splits the pending set into three outputs: 8-bit channels, 16-bit channels and the bus-master request.

Top module: `dmareq_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every pending flag is 0, so pending, pend_narrow, pend_wide and busmaster_req are all 0.
- R2: A frame on a line is a low start bit, then channel bits 2, 1 and 0 in that order, then the ACT bit, with the line level (high = 1) as the bit value. The frame is then sampled in a gap clock. If the gap is high, the frame takes effect on that same clock edge.
- R3: A committed frame with ACT = 1 sets the pending flag of the channel it names. No flag becomes set in any other way.
- R4: A committed frame with ACT = 0 clears the pending flag of the channel it names. The exception is when a set for that channel is committed in the same cycle.
- R5: A new start bit may follow the gap clock directly. Frames sent back to back on one line for different channels are all kept.
- R6: The two lines are decoded independently. Frames that arrive at the same time on both lines both take effect.
- R7: When both lines commit a frame for the same channel in the same cycle, a set from either line wins. The flag clears only if both frames carry ACT = 0.
- R8: If the gap clock is sampled low, the frame is dropped and leaves every pending flag unchanged. The line is then ignored until it is sampled high. After that, a new start bit begins a normal frame.
- R9: A service acknowledge (svc_ack = 1 with svc_chan) clears that channel's flag on the next edge. A set for the same channel committed in the same cycle wins over the acknowledge.
- R10: Channels 0 to 3 are reported on pend_narrow (8-bit). Channels 5 to 7 are reported on pend_wide (16-bit). Channel 4 is reported only on busmaster_req. The bit positions are the channel numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_line_n | input | 2 | Serial request lines, one per peripheral, idle high |
| svc_ack | input | 1 | Service acknowledge strobe for one cycle |
| svc_chan | input | 3 | Channel whose transfer has completed |
| pending | output | 8 | Pending flag per channel, bit n = channel n |
| pend_narrow | output | 8 | Pending flags of the 8-bit channels 0 to 3, other bits 0 |
| pend_wide | output | 8 | Pending flags of the 16-bit channels 5 to 7, other bits 0 |
| busmaster_req | output | 1 | Channel 4 bus-master request is pending |

## Verification
The bench sends frames back to back with only the single gap clock between them. A receiver that needs a second idle clock would drop the following frame, and one that takes the gap low as a new start would decode garbage.

Several collisions in the same cycle are exercised:
- A set on one line with a clear for the same channel on the other. A table that lets clear win loses the request.
- A set in the same cycle as an acknowledge. A table that lets the acknowledge win loses the request.
- An acknowledge alongside a set for a different channel. Decoding the acknowledge wrongly would clear the wrong flag.

A frame with a low gap clock, followed by a held-low line, checks that a decoder committing on the ACT bit would wrongly set the flag. It also checks that a decoder which fails to wait for the line to go high would start a bogus frame.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int unsigned DEF_NUM_LINES  = 2;
    localparam int unsigned DEF_CHAN_BITS  = 3;
    localparam int unsigned DEF_BM_CHAN    = 4;

    typedef enum logic [2:0] {
        RX_IDLE = 3'd0,
        RX_CHAN = 3'd1,
        RX_ACT  = 3'd2,
        RX_GAP  = 3'd3,
        RX_ERR  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/dmareq_frame_rx.sv
module dmareq_frame_rx
    import dmareq_pkg::*;
#(
    parameter int unsigned CHAN_BITS = DEF_CHAN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_n,
    output logic                 ev_valid,
    output logic [CHAN_BITS-1:0] ev_chan,
    output logic                 ev_act
);

    localparam int unsigned CNT_W = (CHAN_BITS > 1) ? $clog2(CHAN_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAN_BITS - 1);

    rx_state_e            state_q;
    rx_state_e            state_nx;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [CHAN_BITS-1:0] chan_sh_q;
    logic                 act_q;

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RX_IDLE: if (!line_n)              state_nx = RX_CHAN;
            RX_CHAN: if (bit_cnt_q == LAST_BIT) state_nx = RX_ACT;
            RX_ACT:                            state_nx = RX_GAP;
            RX_GAP:  state_nx = line_n ? RX_IDLE : RX_ERR;
            RX_ERR:  if (line_n)               state_nx = RX_IDLE;
            default:                           state_nx = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            chan_sh_q <= '0;
            act_q     <= 1'b0;
        end else begin
            unique case (state_q)
                RX_IDLE: bit_cnt_q <= '0;
                RX_CHAN: begin
                    chan_sh_q <= CHAN_BITS'({chan_sh_q, line_n});
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                RX_ACT:  act_q <= line_n;
                RX_GAP, RX_ERR: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ev_valid = (state_q == RX_GAP) && line_n;
        ev_chan  = chan_sh_q;
        ev_act   = act_q;
    end

endmodule

// File: rtl/dmareq_pending_table.sv
module dmareq_pending_table #(
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned CHAN_BITS = 3,
    localparam int unsigned NUM_CHAN = 1 << CHAN_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LINES-1:0]                ev_valid,
    input  logic [NUM_LINES-1:0][CHAN_BITS-1:0] ev_chan,
    input  logic [NUM_LINES-1:0]                ev_act,
    input  logic                                svc_ack,
    input  logic [CHAN_BITS-1:0]                svc_chan,
    output logic [NUM_CHAN-1:0]                 pending
);

    logic [NUM_CHAN-1:0] set_hit;
    logic [NUM_CHAN-1:0] clr_hit;
    logic [NUM_CHAN-1:0] pend_nx;

    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (ev_valid[l]) begin
                if (ev_act[l]) set_hit[ev_chan[l]] = 1'b1;
                else           clr_hit[ev_chan[l]] = 1'b1;
            end
        end
        if (svc_ack) clr_hit[svc_chan] = 1'b1;
    end

    // set has priority over any clear source
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign pend_nx[c] = set_hit[c] | (pending[c] & ~clr_hit[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= '0;
        else        pending <= pend_nx;
    end

endmodule

// File: rtl/dmareq_chan_class.sv
module dmareq_chan_class #(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned BM_CHAN  = 4
) (
    input  logic [NUM_CHAN-1:0] pending,
    output logic [NUM_CHAN-1:0] pend_narrow,
    output logic [NUM_CHAN-1:0] pend_wide,
    output logic                busmaster_req
);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_cls
        if (c < BM_CHAN) begin : g_narrow
            assign pend_narrow[c] = pending[c];
            assign pend_wide[c]   = 1'b0;
        end else if (c > BM_CHAN) begin : g_wide
            assign pend_narrow[c] = 1'b0;
            assign pend_wide[c]   = pending[c];
        end else begin : g_bm
            assign pend_narrow[c] = 1'b0;
            assign pend_wide[c]   = 1'b0;
            assign busmaster_req  = pending[c];
        end
    end

endmodule

// File: rtl/dmareq_decoder.sv
module dmareq_decoder
    import dmareq_pkg::*;
#(
    parameter int unsigned NUM_LINES = DEF_NUM_LINES,
    parameter int unsigned CHAN_BITS = DEF_CHAN_BITS,
    parameter int unsigned BM_CHAN   = DEF_BM_CHAN,
    localparam int unsigned NUM_CHAN = 1 << CHAN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_line_n,
    input  logic                 svc_ack,
    input  logic [CHAN_BITS-1:0] svc_chan,
    output logic [NUM_CHAN-1:0]  pending,
    output logic [NUM_CHAN-1:0]  pend_narrow,
    output logic [NUM_CHAN-1:0]  pend_wide,
    output logic                 busmaster_req
);

    logic [NUM_LINES-1:0]                ev_valid;
    logic [NUM_LINES-1:0][CHAN_BITS-1:0] ev_chan;
    logic [NUM_LINES-1:0]                ev_act;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_rx
        dmareq_frame_rx #(
            .CHAN_BITS (CHAN_BITS)
        ) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_n   (req_line_n[l]),
            .ev_valid (ev_valid[l]),
            .ev_chan  (ev_chan[l]),
            .ev_act   (ev_act[l])
        );
    end

    dmareq_pending_table #(
        .NUM_LINES (NUM_LINES),
        .CHAN_BITS (CHAN_BITS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_chan  (ev_chan),
        .ev_act   (ev_act),
        .svc_ack  (svc_ack),
        .svc_chan (svc_chan),
        .pending  (pending)
    );

    dmareq_chan_class #(
        .NUM_CHAN (NUM_CHAN),
        .BM_CHAN  (BM_CHAN)
    ) u_class (
        .pending       (pending),
        .pend_narrow   (pend_narrow),
        .pend_wide     (pend_wide),
        .busmaster_req (busmaster_req)
    );

endmodule

// File: rtl/dmareq_decoder_chk.sv
module dmareq_decoder_chk #(
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned CHAN_BITS = 3,
    parameter int unsigned BM_CHAN   = 4,
    localparam int unsigned NUM_CHAN = 1 << CHAN_BITS
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                svc_ack,
    input logic [CHAN_BITS-1:0]                svc_chan,
    input logic [NUM_CHAN-1:0]                 pending,
    input logic [NUM_CHAN-1:0]                 pend_narrow,
    input logic [NUM_CHAN-1:0]                 pend_wide,
    input logic                                busmaster_req,
    input logic [NUM_LINES-1:0]                ev_valid,
    input logic [NUM_LINES-1:0][CHAN_BITS-1:0] ev_chan,
    input logic [NUM_LINES-1:0]                ev_act
);

    logic [NUM_CHAN-1:0] set_vec;
    logic [NUM_CHAN-1:0] bm_vec;

    always_comb begin
        set_vec = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (ev_valid[l] && ev_act[l]) set_vec[ev_chan[l]] = 1'b1;
        end
        bm_vec = '0;
        bm_vec[BM_CHAN] = busmaster_req;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> pending == '0); // R1

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_valid[l] && ev_act[l] |=> pending[$past(ev_chan[l])]); // R3
        AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_valid[l] && !ev_act[l] && !set_vec[ev_chan[l]] |=> !pending[$past(ev_chan[l])]); // R4
        AST_EVENT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            ev_valid[l] |=> !ev_valid[l]); // R2
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
        AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            !pending[c] && !set_vec[c] |=> !pending[c]); // R3
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ack && !set_vec[svc_chan] |=> !pending[$past(svc_chan)]); // R9

    AST_CLASS_PARTITION: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_narrow | pend_wide | bm_vec) == pending) && ((pend_narrow & pend_wide) == '0)); // R10

endmodule

bind dmareq_decoder dmareq_decoder_chk #(
    .NUM_LINES (NUM_LINES),
    .CHAN_BITS (CHAN_BITS),
    .BM_CHAN   (BM_CHAN)
) u_chk (.*);

// File: tb/dmareq_decoder_tb.sv
module dmareq_decoder_tb;

    typedef struct {
        logic [7:0] exp_pend;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_line_n = 2'b11;
    logic       svc_ack = 1'b0;
    logic [2:0] svc_chan = 3'd0;
    logic [7:0] pending;
    logic [7:0] pend_narrow;
    logic [7:0] pend_wide;
    logic       busmaster_req;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_item_t exp_q[$];
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    dmareq_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .req_line_n (req_line_n),
        .svc_ack (svc_ack), .svc_chan (svc_chan), .pending (pending),
        .pend_narrow (pend_narrow), .pend_wide (pend_wide),
        .busmaster_req (busmaster_req)
    );

    function automatic logic [5:0] frm(input logic [2:0] ch, input logic act);
        return {1'b0, ch, act, 1'b1};
    endfunction

    localparam logic [5:0] IDLE6 = 6'b111111;

    // drives bit i of both sequences on successive negedges (MSB first)
    task automatic run_bits(input logic [5:0] s0, input logic [5:0] s1,
                            input bit ack_on_last, input logic [2:0] ack_ch);
        for (int i = 5; i >= 0; i--) begin
            req_line_n = {s1[i], s0[i]};
            svc_ack    = ack_on_last && (i == 0);
            svc_chan   = ack_ch;
            @(negedge clk);
        end
        req_line_n = 2'b11;
        svc_ack    = 1'b0;
    endtask

    task automatic push(input string tag);
        exp_item_t it;
        it.exp_pend = model;
        it.tag      = tag;
        exp_q.push_back(it);
    endtask

    task automatic do_ack(input logic [2:0] ch);
        svc_ack  = 1'b1;
        svc_chan = ch;
        @(negedge clk);
        svc_ack  = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them to the outputs
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            #1;
            begin
                exp_item_t it;
                it = exp_q.pop_front();
                chk({it.tag, " pending"}, pending, it.exp_pend);
                chk({it.tag, " R10 class"}, {pend_wide[7:5], busmaster_req, pend_narrow[3:0]},
                    {it.exp_pend[7:5], it.exp_pend[4], it.exp_pend[3:0]});
                chk({it.tag, " R10 zero bits"}, {pend_wide[4:0], pend_narrow[7:4]}, 8'h00);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R1 during reset", pending, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 after reset");

        run_bits(frm(3'd2, 1'b1), IDLE6, 0, 3'd0); model = 8'h04; push("R2 R3 line0 ch2 set");
        run_bits(IDLE6, frm(3'd5, 1'b1), 0, 3'd0); model = 8'h24; push("R3 R6 line1 ch5 set");
        run_bits(frm(3'd3, 1'b1), IDLE6, 0, 3'd0); model = 8'h2C; push("R5 b2b ch3");
        run_bits(frm(3'd0, 1'b1), IDLE6, 0, 3'd0); model = 8'h2D; push("R5 b2b ch0");
        run_bits(frm(3'd7, 1'b1), IDLE6, 0, 3'd0); model = 8'hAD; push("R5 b2b ch7");
        run_bits(IDLE6, frm(3'd4, 1'b1), 0, 3'd0); model = 8'hBD; push("R10 ch4 busmaster");
        run_bits(frm(3'd3, 1'b0), IDLE6, 0, 3'd0); model = 8'hB5; push("R4 clear ch3");
        run_bits(frm(3'd6, 1'b1), frm(3'd6, 1'b0), 0, 3'd0); model = 8'hF5; push("R7 set beats clear ch6");
        run_bits(frm(3'd2, 1'b0), frm(3'd1, 1'b1), 0, 3'd0); model = 8'hF3; push("R6 parallel clr2 set1");
        run_bits(frm(3'd6, 1'b0), frm(3'd6, 1'b0), 0, 3'd0); model = 8'hB3; push("R7 both clear ch6");

        run_bits({1'b0, 3'd3, 1'b1, 1'b0}, IDLE6, 0, 3'd0); push("R8 low gap dropped");
        run_bits(6'b000111, IDLE6, 0, 3'd0); push("R8 held low ignored");
        run_bits(frm(3'd3, 1'b1), IDLE6, 0, 3'd0); model = 8'hBB; push("R8 recovery ch3 set");

        do_ack(3'd5); model = 8'h9B; push("R9 ack ch5");
        run_bits(IDLE6, frm(3'd7, 1'b1), 1, 3'd7); push("R9 set beats ack ch7");
        run_bits(frm(3'd1, 1'b1), IDLE6, 1, 3'd0); model = 8'h9A; push("R9 ack ch0 with set ch1");
        run_bits(IDLE6, frm(3'd4, 1'b0), 0, 3'd0); model = 8'h8A; push("R4 R10 clear ch4");

        repeat (4) @(negedge clk);
        wait (exp_q.size() == 0);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule